// File: doc/BRIEF.md
# Low-Power Mode Wakeup Controller

This block sequences a small SoC into and out of four low-power modes. Software asks for a mode with a one-cycle request. The block then waits for software to confirm that its context is saved. For the modes that keep external memory alive, it also raises a self-refresh request and waits for that to be acknowledged. Only then does it switch off the domain power enables, the oscillator enables and, in the deepest mode, the external regulator enable that the mode calls for.

While the chip sleeps, the wakeup lines are brought into the clock domain and their rising edges are detected. Each edge is filtered against the set of sources the current mode accepts and a software enable mask. The first accepted edge restores power and waits a programmable settle time. The block then releases self-refresh, waits for the release to be acknowledged and pulses a resume output. Every source accepted in that cycle is kept in a status register. The status register is cleared only by power-on reset or by a write-one-to-clear, so a zero value means a cold boot.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset, all domain, oscillator and regulator enables are 1, self-refresh request, busy, resume, error and wake status are all 0.
- R2: After a mode request, nothing is powered down and self-refresh is not requested until the context-saved input is seen. For memory-retaining modes (codes 1, 2, 3), self-refresh is requested next, and domain power is removed only in the cycle after the self-refresh acknowledge is seen.
- R3: While asleep, mode code 0 (I/O retention) turns off core and MCU domains. Code 1 (deep sleep) also turns off both. Code 2 (MCU-only) turns off only the core domain. Code 3 (standby) keeps both domains on. Codes 1 to 3 hold the self-refresh request high throughout sleep.
- R4: The oscillator enables go low while asleep in code 0. They also go low in code 1 when neither the timer (bit 1) nor the RTC (bit 2) wake enable is set. Otherwise they stay high.
- R5: Wake source bit order: 0 I/O-bank pin, 1 timer, 2 RTC, 3 UART, 4 I2C, 5 MCU GPIO, 6 I/O daisy chain, 7 USB, 8 MCU-domain interrupt, 9 any other SoC interrupt. Code 0 accepts bit 0 only. Code 1 accepts bits 1 to 7. Code 2 accepts bits 1 to 8. Code 3 accepts bits 1 to 9. Other edges are ignored.
- R6: A wake line is acted on at the third rising clock edge after it rises. Only a rising edge wakes, so a line already high when sleep begins does not.
- R7: All sources accepted in the waking cycle are set together in the wake status. Status bits are cleared by writing one to the clear input, and otherwise hold their value until reset.
- R8: On wake, power is restored at once. With settle count N, the exit sequence then waits N+1 cycles. After that, self-refresh is released (codes 1 to 3). Resume pulses for one cycle after the release acknowledge falls, or right after settle in code 0.
- R9: A mode request while busy is ignored and sets a sticky error flag, which is cleared by the error-clear input.
- R10: In code 0, the external regulator enable is low while asleep and returns high when the I/O-bank pin wakes the chip. No self-refresh is requested.
- R11: A source whose wake enable bit is 0 never wakes the chip or sets status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| req_valid_i | input | 1 | One-cycle mode request strobe |
| req_mode_i | input | 2 | Requested mode code (0 deepest, 3 lightest) |
| ctx_saved_i | input | 1 | Software context-saved acknowledge |
| sr_ack_i | input | 1 | Memory self-refresh acknowledge (level) |
| wake_i | input | 10 | Asynchronous wakeup lines |
| wake_en_i | input | 10 | Per-source wake enable mask |
| settle_cnt_i | input | 8 | Power settle count in cycles |
| status_clr_i | input | 10 | Write-one-to-clear strobes for wake status |
| err_clr_i | input | 1 | Clears the error flag |
| pd_core_en_o | output | 1 | Core domain power enable |
| pd_mcu_en_o | output | 1 | MCU domain power enable |
| sr_req_o | output | 1 | Memory self-refresh request |
| osc_en_o | output | 2 | Oscillator enables |
| pmic_en_o | output | 1 | External regulator enable |
| busy_o | output | 1 | A transition or sleep is in progress |
| resume_o | output | 1 | One-cycle resume pulse |
| err_o | output | 1 | Sticky rejected-request flag |
| wake_status_o | output | 10 | Latched wake sources |

## Verification
The assertions assume that the self-refresh acknowledge behaves as a level handshake. It rises only after the request rises and falls only after the request falls. They also assume that context-saved is only asserted while the block waits for it. The bench drives the acknowledge the same way: it raises it only once it sees the request high, and drops it only once the request has gone low. It drives wakeup lines and strobes on the falling clock edge, and holds each wake line high for at least three cycles so that the synchronizer always sees it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int NSRC = 10;

  localparam int SRC_IOB  = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_RTC  = 2;
  localparam int SRC_MIRQ = 8;

  typedef enum logic [1:0] {
    MODE_IOR  = 2'd0,
    MODE_DEEP = 2'd1,
    MODE_MCU  = 2'd2,
    MODE_STBY = 2'd3
  } lp_mode_e;

  typedef enum logic [2:0] {
    ST_ACT, ST_CTX, ST_SRW, ST_SLP, ST_SET, ST_REL
  } seq_st_e;

  function automatic logic [NSRC-1:0] mode_mask(lp_mode_e m);
    logic [NSRC-1:0] k;
    case (m)
      MODE_IOR:  k = NSRC'(1) << SRC_IOB;
      MODE_DEEP: k = ((NSRC'(1) << SRC_MIRQ) - NSRC'(1)) & ~(NSRC'(1) << SRC_IOB);
      MODE_MCU:  k = ((NSRC'(1) << (SRC_MIRQ + 1)) - NSRC'(1)) & ~(NSRC'(1) << SRC_IOB);
      default:   k = ~(NSRC'(1) << SRC_IOB);
    endcase
    return k;
  endfunction

  function automatic logic uses_sr(lp_mode_e m);
    return m != MODE_IOR;
  endfunction
endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= async_i[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[i] = s2_q & ~s3_q;

    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]); // R6
  end
endmodule

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter
  import lpm_pkg::*;
(
  input  logic [NSRC-1:0] rise_i,
  input  logic [NSRC-1:0] en_i,
  input  lp_mode_e        mode_i,
  input  logic            sleep_i,
  output logic [NSRC-1:0] acc_o,
  output logic            any_o
);
  always_comb begin
    acc_o = '0;
    if (sleep_i) acc_o = rise_i & en_i & mode_mask(mode_i);
  end
  assign any_o = |acc_o;
endmodule

// File: rtl/lpm_wake_status.sv
module lpm_wake_status #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] q;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end
  assign status_o = q;

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q)); // R7
  AST_STATUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i))); // R7
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NUM_OSC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_mode_i,
  input  logic               ctx_saved_i,
  input  logic               sr_ack_i,
  input  logic               wake_any_i,
  input  logic [CNT_W-1:0]   settle_i,
  input  logic               err_clr_i,
  input  logic               tmr_wake_en_i,
  output lp_mode_e           mode_o,
  output logic               sleep_o,
  output logic               pd_core_en_o,
  output logic               pd_mcu_en_o,
  output logic               sr_req_o,
  output logic [NUM_OSC-1:0] osc_en_o,
  output logic               pmic_en_o,
  output logic               busy_o,
  output logic               resume_o,
  output logic               err_o
);
  seq_st_e          st_q;
  lp_mode_e         mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q, resume_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_ACT;
      mode_q   <= MODE_STBY;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      if (err_clr_i) err_q <= 1'b0;
      if (req_valid_i && st_q != ST_ACT) err_q <= 1'b1;
      case (st_q)
        ST_ACT: if (req_valid_i) begin
          mode_q <= lp_mode_e'(req_mode_i);
          st_q   <= ST_CTX;
        end
        ST_CTX: if (ctx_saved_i) begin
          if (uses_sr(mode_q)) st_q <= ST_SRW;
          else                 st_q <= ST_SLP;
        end
        ST_SRW: if (sr_ack_i) st_q <= ST_SLP;
        ST_SLP: if (wake_any_i) begin
          st_q  <= ST_SET;
          cnt_q <= settle_i;
        end
        ST_SET: begin
          if (cnt_q == '0) begin
            if (uses_sr(mode_q)) st_q <= ST_REL;
            else begin
              st_q     <= ST_ACT;
              resume_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_REL: if (!sr_ack_i) begin
          st_q     <= ST_ACT;
          resume_q <= 1'b1;
        end
        default: st_q <= ST_ACT;
      endcase
    end
  end

  logic slp, osc_off;
  assign slp          = (st_q == ST_SLP);
  assign sleep_o      = slp;
  assign mode_o       = mode_q;
  assign pd_core_en_o = !(slp && mode_q != MODE_STBY);
  assign pd_mcu_en_o  = !(slp && (mode_q == MODE_IOR || mode_q == MODE_DEEP));
  assign sr_req_o     = uses_sr(mode_q) &&
                        (st_q == ST_SRW || st_q == ST_SLP || st_q == ST_SET);
  assign osc_off      = slp && (mode_q == MODE_IOR ||
                                (mode_q == MODE_DEEP && !tmr_wake_en_i));
  assign osc_en_o     = {NUM_OSC{!osc_off}};
  assign pmic_en_o    = !(slp && mode_q == MODE_IOR);
  assign busy_o       = (st_q != ST_ACT);
  assign resume_o     = resume_q;
  assign err_o        = err_q;

  AST_PWR_AFTER_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pd_core_en_o) && uses_sr(mode_q)) |-> $past(sr_ack_i)); // R2
  AST_SR_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && uses_sr(mode_q)) |-> sr_req_o); // R3
  AST_REJECT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy_o) |=> err_o); // R9
  AST_RESUME_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (!sr_req_o && pd_core_en_o && pd_mcu_en_o && !busy_o)); // R8
  AST_PMIC_OFF_IOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pmic_en_o |-> (mode_q == MODE_IOR && !pd_mcu_en_o && !sr_req_o)); // R10
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
  import lpm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NUM_OSC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_mode_i,
  input  logic               ctx_saved_i,
  input  logic               sr_ack_i,
  input  logic [NSRC-1:0]    wake_i,
  input  logic [NSRC-1:0]    wake_en_i,
  input  logic [CNT_W-1:0]   settle_cnt_i,
  input  logic [NSRC-1:0]    status_clr_i,
  input  logic               err_clr_i,
  output logic               pd_core_en_o,
  output logic               pd_mcu_en_o,
  output logic               sr_req_o,
  output logic [NUM_OSC-1:0] osc_en_o,
  output logic               pmic_en_o,
  output logic               busy_o,
  output logic               resume_o,
  output logic               err_o,
  output logic [NSRC-1:0]    wake_status_o
);
  logic [NSRC-1:0] rise, acc;
  logic            acc_any, sleep;
  lp_mode_e        mode;

  lpm_wake_sync #(.W(NSRC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (wake_i),
    .rise_o  (rise)
  );

  lpm_wake_filter u_filt (
    .rise_i  (rise),
    .en_i    (wake_en_i),
    .mode_i  (mode),
    .sleep_i (sleep),
    .acc_o   (acc),
    .any_o   (acc_any)
  );

  lpm_wake_status #(.W(NSRC)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (acc),
    .clr_i    (status_clr_i),
    .status_o (wake_status_o)
  );

  lpm_seq #(.CNT_W(CNT_W), .NUM_OSC(NUM_OSC)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_mode_i    (req_mode_i),
    .ctx_saved_i   (ctx_saved_i),
    .sr_ack_i      (sr_ack_i),
    .wake_any_i    (acc_any),
    .settle_i      (settle_cnt_i),
    .err_clr_i     (err_clr_i),
    .tmr_wake_en_i (wake_en_i[SRC_TMR] | wake_en_i[SRC_RTC]),
    .mode_o        (mode),
    .sleep_o       (sleep),
    .pd_core_en_o  (pd_core_en_o),
    .pd_mcu_en_o   (pd_mcu_en_o),
    .sr_req_o      (sr_req_o),
    .osc_en_o      (osc_en_o),
    .pmic_en_o     (pmic_en_o),
    .busy_o        (busy_o),
    .resume_o      (resume_o),
    .err_o         (err_o)
  );

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc != '0) |-> (busy_o && (!pd_core_en_o || sr_req_o))); // R5
endmodule

// File: tb/lpm_wake_ctrl_test.sv
`timescale 1ns/1ps
module lpm_wake_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic       ctx_saved = 1'b0;
  logic       sr_ack = 1'b0;
  logic [9:0] wake = '0;
  logic [9:0] wake_en = '1;
  logic [7:0] settle = 8'd4;
  logic [9:0] st_clr = '0;
  logic       err_clr = 1'b0;
  logic       pd_core, pd_mcu, sr_req, pmic, busy, resume, err;
  logic [1:0] osc;
  logic [9:0] wstat;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpm_wake_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .ctx_saved_i(ctx_saved), .sr_ack_i(sr_ack), .wake_i(wake), .wake_en_i(wake_en),
    .settle_cnt_i(settle), .status_clr_i(st_clr), .err_clr_i(err_clr),
    .pd_core_en_o(pd_core), .pd_mcu_en_o(pd_mcu), .sr_req_o(sr_req), .osc_en_o(osc),
    .pmic_en_o(pmic), .busy_o(busy), .resume_o(resume), .err_o(err),
    .wake_status_o(wstat)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  // request, ack context, ack self-refresh; returns asleep at a negedge
  task automatic enter(logic [1:0] m);
    @(negedge clk); req_valid = 1'b1; req_mode = m;
    @(negedge clk); req_valid = 1'b0; ctx_saved = 1'b1;
    @(negedge clk); ctx_saved = 1'b0;
    if (m != 2'd0) begin
      sr_ack = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic wake_up(logic [9:0] bits);
    wake = wake | bits;
    nclk(3);
  endtask

  task automatic finish_exit(string req);
    bit seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (!sr_req) sr_ack = 1'b0;
      if (resume) seen = 1;
    end
    chk(req, "resume seen", seen, 1);
    wake = '0;
    @(negedge clk); st_clr = '1;
    @(negedge clk); st_clr = '0;
  endtask

  task automatic t_reset;
    chk("R1", "pd_core", pd_core, 1);
    chk("R1", "pd_mcu", pd_mcu, 1);
    chk("R1", "osc", osc, 3);
    chk("R1", "pmic", pmic, 1);
    chk("R1", "sr_req", sr_req, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "resume", resume, 0);
    chk("R1", "err", err, 0);
    chk("R1", "status", wstat, 0);
  endtask

  task automatic t_deep;
    @(negedge clk); req_valid = 1'b1; req_mode = 2'd1;
    @(negedge clk); req_valid = 1'b0;
    chk("R2", "busy after req", busy, 1);
    nclk(3);
    chk("R2", "sr_req before ctx", sr_req, 0);
    chk("R2", "pd_core before ctx", pd_core, 1);
    ctx_saved = 1'b1;
    @(negedge clk); ctx_saved = 1'b0;
    chk("R2", "sr_req after ctx", sr_req, 1);
    nclk(2);
    chk("R2", "pd_core before ack", pd_core, 1);
    sr_ack = 1'b1;
    @(negedge clk);
    chk("R3", "deep pd_core", pd_core, 0);
    chk("R3", "deep pd_mcu", pd_mcu, 0);
    chk("R3", "deep sr_req", sr_req, 1);
    chk("R3", "deep pmic", pmic, 1);
    chk("R4", "deep osc timers on", osc, 3);
    wake[8] = 1'b1; wake[9] = 1'b1;
    nclk(5);
    chk("R5", "deep ignores mcu irq", pd_core, 0);
    chk("R5", "deep status after ignored", wstat, 0);
    wake[3] = 1'b1; wake[4] = 1'b1;
    nclk(1);
    chk("R6", "status after 1 edge", wstat, 0);
    nclk(1);
    chk("R6", "still asleep after 2 edges", pd_core, 0);
    nclk(1);
    chk("R6", "awake after 3 edges", pd_core, 1);
    chk("R7", "multi-source status", wstat, 10'h018);
    chk("R8", "sr held in settle", sr_req, 1);
    nclk(4);
    chk("R8", "sr held at settle end", sr_req, 1);
    nclk(1);
    chk("R8", "sr released", sr_req, 0);
    chk("R8", "no resume before ack drop", resume, 0);
    sr_ack = 1'b0;
    nclk(1);
    chk("R8", "resume pulse", resume, 1);
    chk("R8", "idle at resume", busy, 0);
    nclk(1);
    chk("R8", "resume one cycle", resume, 0);
    wake = '0;
    st_clr = 10'h008;
    @(negedge clk); st_clr = '0;
    chk("R7", "w1c one bit", wstat, 10'h010);
    nclk(2);
    chk("R7", "status holds", wstat, 10'h010);
    st_clr = 10'h010;
    @(negedge clk); st_clr = '0;
    chk("R7", "w1c last bit", wstat, 0);
  endtask

  task automatic t_ior;
    enter(2'd0);
    chk("R10", "ior pmic off", pmic, 0);
    chk("R10", "ior no sr", sr_req, 0);
    chk("R3", "ior pd_core", pd_core, 0);
    chk("R3", "ior pd_mcu", pd_mcu, 0);
    chk("R4", "ior osc", osc, 0);
    wake[3] = 1'b1;
    nclk(5);
    chk("R5", "ior ignores uart", pmic, 0);
    wake_up(10'h001);
    chk("R10", "ior pmic back", pmic, 1);
    chk("R10", "ior status", wstat, 10'h001);
    finish_exit("R10");
  endtask

  task automatic t_mcu;
    enter(2'd2);
    chk("R3", "mcu pd_core", pd_core, 0);
    chk("R3", "mcu pd_mcu", pd_mcu, 1);
    chk("R4", "mcu osc", osc, 3);
    wake[9] = 1'b1;
    nclk(5);
    chk("R5", "mcu ignores soc irq", pd_core, 0);
    wake_up(10'h100);
    chk("R5", "mcu irq wakes", wstat, 10'h100);
    finish_exit("R5");
  endtask

  task automatic t_stby;
    wake[9] = 1'b1;
    nclk(4);
    enter(2'd3);
    chk("R3", "stby pd_core", pd_core, 1);
    chk("R3", "stby sr_req", sr_req, 1);
    nclk(6);
    chk("R6", "held level no wake", wstat, 0);
    chk("R6", "still asleep", sr_req, 1);
    wake[9] = 1'b0;
    nclk(4);
    wake_up(10'h200);
    chk("R5", "stby soc irq wakes", wstat, 10'h200);
    finish_exit("R5");
  endtask

  task automatic t_osc_en;
    wake_en = 10'h37F & ~10'h006;  // timers/RTC off, USB (bit 7) disabled
    enter(2'd1);
    chk("R4", "deep osc off", osc, 0);
    wake[7] = 1'b1;
    nclk(5);
    chk("R11", "disabled usb ignored", wstat, 0);
    chk("R11", "still asleep", pd_core, 0);
    wake_up(10'h020);
    chk("R11", "gpio wakes", wstat, 10'h020);
    chk("R4", "osc back", osc, 3);
    finish_exit("R11");
    wake_en = '1;
  endtask

  task automatic t_busy;
    @(negedge clk); req_valid = 1'b1; req_mode = 2'd1;
    @(negedge clk); req_mode = 2'd3;
    @(negedge clk); req_valid = 1'b0;
    chk("R9", "err set", err, 1);
    ctx_saved = 1'b1;
    @(negedge clk); ctx_saved = 1'b0; sr_ack = 1'b1;
    @(negedge clk);
    chk("R9", "mode kept deep", pd_mcu, 0);
    wake_up(10'h002);
    finish_exit("R9");
    chk("R9", "err sticky", err, 1);
    err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R9", "err cleared", err, 0);
  endtask

  initial begin
    nclk(3);
    rst_n = 1'b1;
    nclk(1);
    t_reset();
    t_deep();
    t_ior();
    t_mcu();
    t_stby();
    t_osc_en();
    t_busy();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule